// File: doc/BRIEF.md
# Posted Write Buffer with Single Read Bypass

This block sits between a processor core and its external bus and holds up to four posted writes. The core hands it one write per clock. If nothing is stored and the bus can take an operation, the write passes straight through in the same cycle. Otherwise the write is stored and later sent to the bus in arrival order, one per cycle in which the bus is free. When all four entries are full, the block stalls further writes.

A read from the core normally waits until every stored write has reached the bus. There is one exception. If every stored write hit the on-chip cache and the read missed it, the read may pass the stored writes. Memory cannot then hold stale data for that read, because each pending write has already updated the cache. This pass is allowed once. After that, reads wait again until the buffer has emptied completely.

Each accepted write that hit the cache is also signalled to the cache in the cycle it is accepted, whether it is stored or passed through. Operations reach the bus as a single-cycle issue strobe, together with a direction, an address and data. They are only presented in cycles where the bus reports that it is available.

Top module: `wbuf_reorder`

## Requirements
- R1: The buffer stores up to four writes and accepts one new write in every clock cycle in which it is not full.
- R2: When no write is stored, no read is requesting and the bus is available, a requested write is issued on the bus in the same cycle and is not stored.
- R3: A write stored while the bus is unavailable is issued in the first cycle in which the bus becomes available.
- R4: Stored writes are issued on the bus in the order in which they were accepted, each exactly once.
- R5: A read that missed the cache is issued ahead of stored writes, in the first cycle the bus is available, when every stored write was a cache hit and no reorder has occurred since the buffer was last empty.
- R6: A read that hit the cache, or a read requested while any stored write missed the cache, waits until all stored writes have been issued.
- R7: After one read has been reordered ahead of stored writes, a further read waits until the buffer has become empty.
- R8: Once the buffer has become empty, a read may again be reordered ahead of writes stored afterwards.
- R9: While four writes are stored the full output is high, and a write requested then is neither stored nor issued.
- R10: The cache-update strobe is high exactly in the cycle a write with the hit flag set is accepted. It stays low for writes that missed and for writes stalled by the full output.
- R11: On the bus, the direction output is 1 for writes and 0 for reads, and the data output is 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Core write request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_hit | input | 1 | Write hit the on-chip cache |
| wr_full | output | 1 | Buffer full, write request stalled |
| cache_wr_en | output | 1 | Accepted write updates the cache this cycle |
| rd_req | input | 1 | Core read request, held until granted |
| rd_addr | input | AW | Read address |
| rd_miss | input | 1 | Read missed the on-chip cache |
| rd_grant | output | 1 | Read issued to the bus this cycle |
| bus_rdy | input | 1 | Bus accepts an operation this cycle |
| bus_issue | output | 1 | Operation issued to the bus this cycle |
| bus_we | output | 1 | Issued operation is a write |
| bus_addr | output | AW | Address of issued operation |
| bus_data | output | DW | Data of issued write, zero for reads |

## Verification
The assertions assume that the core holds a read request and its address and miss flag steady until the grant appears. They also assume that the core never holds a write request while the full output is high and expects it to be taken. The stimulus drives every input just after a rising edge. It keeps each read asserted until the grant has been seen and then drops it. It releases a stalled write before the bus is freed, so that the single stalled write is never expected on the bus.

// File: rtl/wbuf_pkg.sv
// Shared types for the posted write buffer.
package wbuf_pkg;

    // Source of the operation issued on the bus in the current cycle.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_READ   = 2'd1,
        SRC_DRAIN  = 2'd2,
        SRC_BYPASS = 2'd3
    } issue_src_e;

endpackage

// File: rtl/wbuf_fifo.sv
// Ring storage for posted writes: address, data and cache-hit flag per entry.
// Assumes the caller never pushes when full nor pops when empty.
module wbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          push_hit,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          head_hit,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam bit POW2 = (DEPTH == (1 << PW));

    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];
    logic [DEPTH-1:0] hit_mem;
    logic [PW-1:0] wp_q, rp_q, wp_nx, rp_nx;
    logic [CW-1:0] cnt_q;

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise.
    generate
        if (POW2) begin : g_wrap_pow2
            assign wp_nx = wp_q + PW'(1);
            assign rp_nx = rp_q + PW'(1);
        end else begin : g_wrap_cmp
            assign wp_nx = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
            assign rp_nx = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
        end
    endgenerate

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_nx;
            if (pop)  rp_q <= rp_nx;
            if (push && !pop)      cnt_q <= cnt_q + CW'(1);
            else if (pop && !push) cnt_q <= cnt_q - CW'(1);
        end
    end

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[wp_q] <= push_addr;
            data_mem[wp_q] <= push_data;
            hit_mem[wp_q]  <= push_hit;
        end
    end

    // Head view and occupancy flags.
    always_comb begin
        head_addr = addr_mem[rp_q];
        head_data = data_mem[rp_q];
        head_hit  = hit_mem[rp_q];
        full      = (cnt_q == CW'(DEPTH));
        empty     = (cnt_q == '0);
    end

    a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/wbuf_track.sv
// Tracks whether any stored write missed the cache and whether the single
// read reorder has been spent since the buffer was last empty.
// Assumes push/pop follow the storage and pop_hit is the head's hit flag.
module wbuf_track #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_hit,
    input  logic pop,
    input  logic pop_hit,
    input  logic buf_empty,
    input  logic reorder_fire,
    output logic all_hit,
    output logic reorder_used
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] miss_cnt_q;
    logic inc, dec;

    assign inc = push && !push_hit;
    assign dec = pop && !pop_hit;

    // Count of stored writes that missed the cache.
    always_ff @(posedge clk) begin
        if (!rst_n)          miss_cnt_q <= '0;
        else if (inc && !dec) miss_cnt_q <= miss_cnt_q + CW'(1);
        else if (dec && !inc) miss_cnt_q <= miss_cnt_q - CW'(1);
    end

    // Reorder-spent flag: set on a reorder, cleared when the buffer is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)         reorder_used <= 1'b0;
        else if (buf_empty) reorder_used <= 1'b0;
        else if (reorder_fire) reorder_used <= 1'b1;
    end

    assign all_hit = (miss_cnt_q == '0);

    a_r7_single_reorder: assert property (@(posedge clk) disable iff (!rst_n)
        reorder_fire |-> !reorder_used);
    a_r8_clear_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |=> !reorder_used);
    a_r6_miss_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (miss_cnt_q != '0));
    a_r6_empty_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && !push) |=> all_hit);

endmodule

// File: rtl/wbuf_arb.sv
// Chooses the single bus operation of the cycle: qualifying read first,
// then the oldest stored write, then a pass-through write.
// Assumes read requests are held until granted.
module wbuf_arb
    import wbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rdy,
    input  logic       rd_req,
    input  logic       rd_miss,
    input  logic       wr_req,
    input  logic       buf_empty,
    input  logic       all_hit,
    input  logic       reorder_used,
    output issue_src_e src
);
    logic read_ok;

    // Read may go when nothing is stored, or as the single allowed reorder.
    assign read_ok = rd_req && (buf_empty || (rd_miss && all_hit && !reorder_used));

    // Fixed-priority selection of the bus operation.
    always_comb begin
        if (!bus_rdy)       src = SRC_NONE;
        else if (read_ok)   src = SRC_READ;
        else if (!buf_empty) src = SRC_DRAIN;
        else if (wr_req)    src = SRC_BYPASS;
        else                src = SRC_NONE;
    end

    a_r6_hit_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_miss && !buf_empty) |-> (src != SRC_READ));
    a_r11_idle_bus_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdy |-> (src == SRC_NONE));

endmodule

// File: rtl/wbuf_reorder.sv
// Top of the posted write buffer. Connects storage, miss/reorder tracking
// and the issue arbiter; muxes the bus fields and the cache-update strobe.
// Assumes the bus takes an operation in any cycle where bus_rdy is high.
module wbuf_reorder
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_hit,
    output logic          wr_full,
    output logic          cache_wr_en,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_miss,
    output logic          rd_grant,
    input  logic          bus_rdy,
    output logic          bus_issue,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data
);
    issue_src_e src;
    logic push, pop, full, empty, all_hit, reorder_used, reorder_fire;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic head_hit;

    wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(wr_addr), .push_data(wr_data), .push_hit(wr_hit),
        .pop(pop),
        .head_addr(head_addr), .head_data(head_data), .head_hit(head_hit),
        .full(full), .empty(empty)
    );

    wbuf_track #(.DEPTH(DEPTH)) u_track (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_hit(wr_hit),
        .pop(pop), .pop_hit(head_hit),
        .buf_empty(empty), .reorder_fire(reorder_fire),
        .all_hit(all_hit), .reorder_used(reorder_used)
    );

    wbuf_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .bus_rdy(bus_rdy), .rd_req(rd_req), .rd_miss(rd_miss), .wr_req(wr_req),
        .buf_empty(empty), .all_hit(all_hit), .reorder_used(reorder_used),
        .src(src)
    );

    // Core-side handshakes derived from the chosen operation.
    always_comb begin
        pop          = (src == SRC_DRAIN);
        push         = wr_req && !full && (src != SRC_BYPASS);
        reorder_fire = (src == SRC_READ) && !empty;
        rd_grant     = (src == SRC_READ);
        wr_full      = full;
        cache_wr_en  = wr_req && wr_hit && !full;
    end

    // Bus field selection per operation source.
    always_comb begin
        bus_issue = (src != SRC_NONE);
        bus_we    = (src == SRC_DRAIN) || (src == SRC_BYPASS);
        unique case (src)
            SRC_READ:   begin bus_addr = rd_addr;   bus_data = '0;        end
            SRC_DRAIN:  begin bus_addr = head_addr; bus_data = head_data; end
            SRC_BYPASS: begin bus_addr = wr_addr;   bus_data = wr_data;   end
            default:    begin bus_addr = '0;        bus_data = '0;        end
        endcase
    end

    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdy && wr_req && !rd_req && empty) |-> (bus_issue && bus_we && bus_addr == wr_addr));
    a_r3_drain_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdy && !rd_req && !empty) |-> (bus_issue && bus_we && bus_addr == head_addr));
    a_r10_cache_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_en |-> (wr_req && wr_hit && !wr_full));
    a_r11_read_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> (!bus_we && bus_data == '0));

endmodule

// File: tb/sim_wbuf_reorder.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected bus operations,
// a monitor pops and compares each issued operation.
module sim_wbuf_reorder;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0, wr_hit = 1'b0, rd_req = 1'b0, rd_miss = 1'b0, bus_rdy = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic wr_full, cache_wr_en, rd_grant, bus_issue, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;

    int total = 0;
    int fails = 0;

    logic          q_we   [$];
    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    string         q_tag  [$];

    always #5 clk = ~clk;

    wbuf_reorder #(.DEPTH(4), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_hit(wr_hit),
        .wr_full(wr_full), .cache_wr_en(cache_wr_en),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_miss(rd_miss), .rd_grant(rd_grant),
        .bus_rdy(bus_rdy), .bus_issue(bus_issue), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_data(bus_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic expect_op(input logic we, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input string tag);
        q_we.push_back(we);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Present one write for one cycle; check the cache strobe (R10).
    task automatic put_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic hit);
        wr_req = 1'b1; wr_addr = a; wr_data = d; wr_hit = hit;
        #3;
        check(cache_wr_en == hit, "R10", "cache strobe on accept", 64'(cache_wr_en), 64'(hit));
        tick();
        wr_req = 1'b0; wr_hit = 1'b0;
    endtask

    // Hold a read until granted, then release it.
    task automatic do_read(input logic [AW-1:0] a, input logic miss);
        rd_req = 1'b1; rd_addr = a; rd_miss = miss;
        forever begin
            #3;
            if (rd_grant) break;
            @(posedge clk);
            #1;
        end
        tick();
        rd_req = 1'b0; rd_miss = 1'b0;
    endtask

    task automatic drained(input int n, input string tag);
        repeat (n) tick();
        check(q_we.size() == 0, tag, "expected operations left", 64'(q_we.size()), 64'd0);
    endtask

    // Monitor: compare every issued bus operation with the queue head (R4, R11).
    always @(negedge clk) begin
        if (rst_n && bus_issue) begin
            if (q_we.size() == 0) begin
                total++; fails++;
                $display("FAIL R4 unexpected op we=%0d addr=%h actual=%h expected=none",
                         bus_we, bus_addr, bus_data);
            end else begin
                logic ewe; logic [AW-1:0] ea; logic [DW-1:0] ed; string et;
                ewe = q_we.pop_front(); ea = q_addr.pop_front();
                ed = q_data.pop_front(); et = q_tag.pop_front();
                check(bus_we == ewe && bus_addr == ea && bus_data == ed, et,
                      "bus op {we,addr,data}", {bus_we, bus_addr[30:0], bus_data},
                      {ewe, ea[30:0], ed});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        // Reset state
        check(wr_full == 1'b0, "R9", "full after reset", 64'(wr_full), 64'd0);
        check(bus_issue == 1'b0, "R4", "idle bus after reset", 64'(bus_issue), 64'd0);
        tick();

        // R2: pass-through write with empty buffer and free bus
        bus_rdy = 1'b1;
        expect_op(1'b1, 32'h100, 32'hA0A0_0001, "R2");
        wr_req = 1'b1; wr_addr = 32'h100; wr_data = 32'hA0A0_0001; wr_hit = 1'b1;
        #3;
        check(bus_issue == 1'b1, "R2", "same-cycle issue", 64'(bus_issue), 64'd1);
        check(cache_wr_en == 1'b1, "R10", "strobe on pass-through hit", 64'(cache_wr_en), 64'd1);
        tick();
        wr_req = 1'b0; wr_hit = 1'b0;
        #3;
        check(bus_issue == 1'b0, "R2", "pass-through write not stored", 64'(bus_issue), 64'd0);
        tick();

        // R1, R9, R3, R4: fill four entries while bus busy, stall the fifth
        bus_rdy = 1'b0;
        put_wr(32'h200, 32'h0000_0200, 1'b1);
        put_wr(32'h204, 32'h0000_0204, 1'b0);
        put_wr(32'h208, 32'h0000_0208, 1'b1);
        put_wr(32'h20C, 32'h0000_020C, 1'b0);
        #3;
        check(wr_full == 1'b1, "R9", "full after four writes", 64'(wr_full), 64'd1);
        tick();
        wr_req = 1'b1; wr_addr = 32'h2F0; wr_data = 32'hDEAD_0000; wr_hit = 1'b1;
        #3;
        check(cache_wr_en == 1'b0, "R10", "no strobe for stalled write", 64'(cache_wr_en), 64'd0);
        tick();
        wr_req = 1'b0; wr_hit = 1'b0;
        expect_op(1'b1, 32'h200, 32'h0000_0200, "R4");
        expect_op(1'b1, 32'h204, 32'h0000_0204, "R4");
        expect_op(1'b1, 32'h208, 32'h0000_0208, "R4");
        expect_op(1'b1, 32'h20C, 32'h0000_020C, "R4");
        bus_rdy = 1'b1;
        #3;
        check(bus_issue == 1'b1 && bus_addr == 32'h200, "R3", "drain on first free cycle",
              64'(bus_addr), 64'h200);
        drained(6, "R9");

        // R5: all stored writes hit, read misses -> read goes first
        bus_rdy = 1'b0;
        put_wr(32'h300, 32'h0000_0300, 1'b1);
        put_wr(32'h304, 32'h0000_0304, 1'b1);
        expect_op(1'b0, 32'h3A0, '0, "R5");
        expect_op(1'b1, 32'h300, 32'h0000_0300, "R4");
        expect_op(1'b1, 32'h304, 32'h0000_0304, "R4");
        bus_rdy = 1'b1;
        do_read(32'h3A0, 1'b1);
        drained(4, "R5");

        // R6: a stored miss blocks the reorder
        bus_rdy = 1'b0;
        put_wr(32'h400, 32'h0000_0400, 1'b1);
        put_wr(32'h404, 32'h0000_0404, 1'b0);
        expect_op(1'b1, 32'h400, 32'h0000_0400, "R6");
        expect_op(1'b1, 32'h404, 32'h0000_0404, "R6");
        expect_op(1'b0, 32'h4A0, '0, "R6");
        bus_rdy = 1'b1;
        do_read(32'h4A0, 1'b1);
        drained(3, "R6");

        // R6: a read that hit waits even with all-hit writes
        bus_rdy = 1'b0;
        put_wr(32'h500, 32'h0000_0500, 1'b1);
        put_wr(32'h504, 32'h0000_0504, 1'b1);
        expect_op(1'b1, 32'h500, 32'h0000_0500, "R6");
        expect_op(1'b1, 32'h504, 32'h0000_0504, "R6");
        expect_op(1'b0, 32'h5A0, '0, "R6");
        bus_rdy = 1'b1;
        rd_req = 1'b1; rd_addr = 32'h5A0; rd_miss = 1'b0;
        #3;
        check(rd_grant == 1'b0, "R6", "hit read not reordered", 64'(rd_grant), 64'd0);
        do_read(32'h5A0, 1'b0);
        drained(3, "R6");

        // R7: only one reorder until the buffer empties
        bus_rdy = 1'b0;
        put_wr(32'h600, 32'h0000_0600, 1'b1);
        put_wr(32'h604, 32'h0000_0604, 1'b1);
        put_wr(32'h608, 32'h0000_0608, 1'b1);
        expect_op(1'b0, 32'h6A0, '0, "R5");
        expect_op(1'b1, 32'h600, 32'h0000_0600, "R7");
        expect_op(1'b1, 32'h604, 32'h0000_0604, "R7");
        expect_op(1'b1, 32'h608, 32'h0000_0608, "R7");
        expect_op(1'b0, 32'h6B0, '0, "R7");
        bus_rdy = 1'b1;
        do_read(32'h6A0, 1'b1);
        rd_req = 1'b1; rd_addr = 32'h6B0; rd_miss = 1'b1;
        #3;
        check(rd_grant == 1'b0, "R7", "second reorder refused", 64'(rd_grant), 64'd0);
        do_read(32'h6B0, 1'b1);

        // R8: after emptying, a reorder is allowed again
        bus_rdy = 1'b0;
        put_wr(32'h700, 32'h0000_0700, 1'b1);
        expect_op(1'b0, 32'h7A0, '0, "R8");
        expect_op(1'b1, 32'h700, 32'h0000_0700, "R8");
        bus_rdy = 1'b1;
        do_read(32'h7A0, 1'b1);
        drained(4, "R8");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule